// File: doc/BRIEF.md
# Prefix and Interrupt-Gating Tracker

This block runs beside a CPU instruction sequencer and keeps track of two things at instruction boundaries: which prefix state applies to the next ordinary instruction, and whether a pending interrupt can be taken. The sequencer pulses a retire strobe for each completed instruction, together with a decoded class code. The block keeps any bank-select override and the sticky flag prefixes through a run of interrupt-suppressing instructions. It resolves conflicting bank prefixes by keeping the newest one. It grants an interrupt only when an ordinary instruction retires.

A small state machine follows the boundary context. `ST_IDLE` means nothing is held. `ST_HELD` means a prefix is in force. `ST_RUN` means a run of non-prefix suppressors is under way with no prefix held. The transitions are:
- T_ARM: a prefix retires in `ST_IDLE` or `ST_RUN`, and the machine moves to `ST_HELD`.
- T_ENTER: a non-prefix suppressor retires in `ST_IDLE`, and the machine moves to `ST_RUN`.
- T_CONSUME: an ordinary retire in `ST_HELD` moves to `ST_IDLE` and clears the prefix state.
- T_LEAVE: an ordinary retire in `ST_RUN` moves to `ST_IDLE`.
- Any other retire, and any cycle without a strobe, leaves the state as it is.

The interrupt priority comparison happens upstream, and its result arrives here as a plain level, `irq_req`.

Top module: `pfx_irq_gate`

## Requirements
- R1: The class codes are: 0 ordinary; 1 interrupt-level load; 2 AND on the flags; 3 OR on the flags; 4 status-word pop; 5 code-bank prefix; 6 data-bank prefix; 7 alternate-bank prefix; 8 stack-bank prefix; 9 keep-flags prefix; 10 shared-register prefix. Codes 1 to 10 suppress interrupts. Codes 0 and 11 to 15 count as ordinary.
- R2: `irq_accept` is high for exactly the one cycle after the clock edge at which an ordinary instruction retires while `irq_req` is high. It is low in every other cycle.
- R3: A suppressing retire never produces `irq_accept`, even when `irq_req` is high. A request raised during a suppressor run is granted at the first ordinary retire that follows, if it is still high then.
- R4: A bank prefix retire sets `bank_ovr` after that edge. The codes are 1 for code bank, 2 for data bank, 3 for alternate bank and 4 for stack bank, and `bank_ovr_vld` goes high. When no bank prefix is held, `bank_ovr` is 0 and `bank_ovr_vld` is 0.
- R5: When several bank prefixes retire one after another, only the most recent one shows on `bank_ovr`.
- R6: A keep-flags prefix sets `ccr_wb_inhibit`, and a shared-register prefix sets `shared_sel`. Neither one changes the held bank override, and a bank prefix does not clear either flag.
- R7: A retire of class 1 to 4 leaves `bank_ovr`, `ccr_wb_inhibit` and `shared_sel` unchanged.
- R8: Prefix outputs stay valid while the ordinary instruction executes. Its retire clears all of them after that edge.
- R9: Synchronous reset clears all prefix outputs and forces `irq_accept` low, even if an ordinary retire with a request happens in the same cycle.
- R10: While `retire_vld` is low, `retire_cls` and `irq_req` have no effect. No output changes and no accept pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retire_vld | input | 1 | Instruction retire strobe |
| retire_cls | input | 4 | Decoded class of the retiring instruction (R1) |
| irq_req | input | 1 | Interrupt request valid, already priority-qualified |
| bank_ovr | output | 3 | Bank-select override code for the next ordinary instruction |
| bank_ovr_vld | output | 1 | High while a bank prefix is held |
| ccr_wb_inhibit | output | 1 | Blocks condition-code writeback for the next ordinary instruction |
| shared_sel | output | 1 | Shared-register prefix held |
| irq_accept | output | 1 | One-cycle interrupt acceptance pulse |

## Verification
The checker tests the following on every cycle:
- No suppressing retire is ever followed by an accept.
- Every accept traces back to an ordinary retire with a request one edge earlier.
- A bank prefix loads its own code.
- Suppressors and idle cycles leave the prefix outputs stable.
- An ordinary retire clears everything.

Only the bench's scenarios can show behaviour that spans whole sequences. Examples are a prefix that survives a multi-instruction suppressor run and then reaches exactly one ordinary instruction, the newest-wins outcome of a chain of conflicting bank prefixes, and a request raised in the middle of a run that is granted only at its end.

// File: rtl/pfx_irq_pkg.sv
package pfx_irq_pkg;

    localparam int CLS_W  = 4;
    localparam int BANK_W = 3;

    // Retire class codes
    localparam logic [CLS_W-1:0] CLS_ORDINARY   = 4'd0;
    localparam logic [CLS_W-1:0] CLS_SUP_LEVEL  = 4'd1;
    localparam logic [CLS_W-1:0] CLS_SUP_AND    = 4'd2;
    localparam logic [CLS_W-1:0] CLS_SUP_OR     = 4'd3;
    localparam logic [CLS_W-1:0] CLS_SUP_POPST  = 4'd4;
    localparam logic [CLS_W-1:0] CLS_PFX_CODE   = 4'd5;
    localparam logic [CLS_W-1:0] CLS_PFX_DATA   = 4'd6;
    localparam logic [CLS_W-1:0] CLS_PFX_ALT    = 4'd7;
    localparam logic [CLS_W-1:0] CLS_PFX_STACK  = 4'd8;
    localparam logic [CLS_W-1:0] CLS_PFX_KEEPCC = 4'd9;
    localparam logic [CLS_W-1:0] CLS_PFX_SHARED = 4'd10;

    // Bank override codes
    localparam logic [BANK_W-1:0] BANK_NONE  = 3'd0;
    localparam logic [BANK_W-1:0] BANK_CODE  = 3'd1;
    localparam logic [BANK_W-1:0] BANK_DATA  = 3'd2;
    localparam logic [BANK_W-1:0] BANK_ALT   = 3'd3;
    localparam logic [BANK_W-1:0] BANK_STACK = 3'd4;

    typedef struct packed {
        logic              ordinary;
        logic              suppress;
        logic              prefix;
        logic              bank_load;
        logic [BANK_W-1:0] bank_code;
        logic              keep_cc;
        logic              shared;
    } cls_info_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HELD = 2'd1,
        ST_RUN  = 2'd2
    } gate_state_e;

endpackage

// File: rtl/pfx_cls_decode.sv
module pfx_cls_decode
    import pfx_irq_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output cls_info_t        info
);

    always_comb begin
        info = '0;
        unique case (cls)
            CLS_SUP_LEVEL, CLS_SUP_AND, CLS_SUP_OR, CLS_SUP_POPST: begin
                info.suppress = 1'b1;
            end
            CLS_PFX_CODE: begin
                info.suppress  = 1'b1;
                info.prefix    = 1'b1;
                info.bank_load = 1'b1;
                info.bank_code = BANK_CODE;
            end
            CLS_PFX_DATA: begin
                info.suppress  = 1'b1;
                info.prefix    = 1'b1;
                info.bank_load = 1'b1;
                info.bank_code = BANK_DATA;
            end
            CLS_PFX_ALT: begin
                info.suppress  = 1'b1;
                info.prefix    = 1'b1;
                info.bank_load = 1'b1;
                info.bank_code = BANK_ALT;
            end
            CLS_PFX_STACK: begin
                info.suppress  = 1'b1;
                info.prefix    = 1'b1;
                info.bank_load = 1'b1;
                info.bank_code = BANK_STACK;
            end
            CLS_PFX_KEEPCC: begin
                info.suppress = 1'b1;
                info.prefix   = 1'b1;
                info.keep_cc  = 1'b1;
            end
            CLS_PFX_SHARED: begin
                info.suppress = 1'b1;
                info.prefix   = 1'b1;
                info.shared   = 1'b1;
            end
            default: begin
                // ordinary and reserved codes
                info.ordinary = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pfx_bank_hold.sv
module pfx_bank_hold
    import pfx_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              clear,
    input  logic [BANK_W-1:0] code_in,
    output logic [BANK_W-1:0] code_q,
    output logic              vld_q
);

    logic [BANK_W-1:0] code_r;

    // newest bank prefix overwrites any older one
    always_ff @(posedge clk) begin
        if (rst) begin
            code_r <= BANK_NONE;
        end else if (load) begin
            code_r <= code_in;
        end else if (clear) begin
            code_r <= BANK_NONE;
        end
    end

    assign code_q = code_r;
    assign vld_q  = (code_r != BANK_NONE);

endmodule

// File: rtl/pfx_gate_fsm.sv
module pfx_gate_fsm
    import pfx_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      retire_vld,
    input  cls_info_t info,
    input  logic      irq_req,
    output logic      bank_load,
    output logic      bank_clear,
    output logic      keep_cc_q,
    output logic      shared_q,
    output logic      irq_accept_q
);

    gate_state_e state_q;
    gate_state_e state_d;
    logic        keep_cc_d;
    logic        shared_d;
    logic        accept_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (retire_vld) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (info.prefix)        state_d = ST_HELD;  // T_ARM
                    else if (info.suppress) state_d = ST_RUN;   // T_ENTER
                end
                ST_HELD: begin
                    if (info.ordinary)      state_d = ST_IDLE;  // T_CONSUME
                end
                ST_RUN: begin
                    if (info.prefix)        state_d = ST_HELD;  // T_ARM
                    else if (info.ordinary) state_d = ST_IDLE;  // T_LEAVE
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs and next flag values
    always_comb begin
        bank_load  = 1'b0;
        bank_clear = 1'b0;
        keep_cc_d  = keep_cc_q;
        shared_d   = shared_q;
        accept_d   = 1'b0;
        if (retire_vld) begin
            unique case (state_q)
                ST_HELD: begin
                    if (info.ordinary) begin
                        bank_clear = 1'b1;
                        keep_cc_d  = 1'b0;
                        shared_d   = 1'b0;
                    end
                end
                ST_IDLE, ST_RUN: begin
                    keep_cc_d = 1'b0;
                    shared_d  = 1'b0;
                end
                default: begin
                    bank_clear = 1'b1;
                    keep_cc_d  = 1'b0;
                    shared_d   = 1'b0;
                end
            endcase
            bank_load = info.bank_load;
            if (info.keep_cc) keep_cc_d = 1'b1;
            if (info.shared)  shared_d  = 1'b1;
            accept_d = info.ordinary & irq_req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            keep_cc_q    <= 1'b0;
            shared_q     <= 1'b0;
            irq_accept_q <= 1'b0;
        end else begin
            keep_cc_q    <= keep_cc_d;
            shared_q     <= shared_d;
            irq_accept_q <= accept_d;
        end
    end

endmodule

// File: rtl/pfx_irq_gate.sv
module pfx_irq_gate
    import pfx_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              retire_vld,
    input  logic [CLS_W-1:0]  retire_cls,
    input  logic              irq_req,
    output logic [BANK_W-1:0] bank_ovr,
    output logic              bank_ovr_vld,
    output logic              ccr_wb_inhibit,
    output logic              shared_sel,
    output logic              irq_accept
);

    cls_info_t info;
    logic      bank_load;
    logic      bank_clear;

    pfx_cls_decode i_decode (
        .cls  (retire_cls),
        .info (info)
    );

    pfx_gate_fsm i_fsm (
        .clk          (clk),
        .rst          (rst),
        .retire_vld   (retire_vld),
        .info         (info),
        .irq_req      (irq_req),
        .bank_load    (bank_load),
        .bank_clear   (bank_clear),
        .keep_cc_q    (ccr_wb_inhibit),
        .shared_q     (shared_sel),
        .irq_accept_q (irq_accept)
    );

    pfx_bank_hold i_bank (
        .clk     (clk),
        .rst     (rst),
        .load    (retire_vld & bank_load),
        .clear   (bank_clear),
        .code_in (info.bank_code),
        .code_q  (bank_ovr),
        .vld_q   (bank_ovr_vld)
    );

endmodule

// File: rtl/pfx_irq_gate_chk.sv
module pfx_irq_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic       retire_vld,
    input logic [3:0] retire_cls,
    input logic       irq_req,
    input logic [2:0] bank_ovr,
    input logic       bank_ovr_vld,
    input logic       ccr_wb_inhibit,
    input logic       shared_sel,
    input logic       irq_accept
);

    logic is_ord;
    logic is_bank;
    logic is_plain_sup;
    logic [2:0] want_code;

    assign is_ord       = (retire_cls == 4'd0) || (retire_cls > 4'd10);
    assign is_bank      = (retire_cls >= 4'd5) && (retire_cls <= 4'd8);
    assign is_plain_sup = (retire_cls >= 4'd1) && (retire_cls <= 4'd4);
    assign want_code    = 3'(retire_cls - 4'd4);

    assert_accept_cause_R2: assert property (@(posedge clk) disable iff (rst)
        irq_accept |-> $past(retire_vld && is_ord && irq_req));

    assert_no_accept_sup_R3: assert property (@(posedge clk) disable iff (rst)
        (retire_vld && !is_ord) |=> !irq_accept);

    assert_bank_load_R4: assert property (@(posedge clk) disable iff (rst)
        (retire_vld && is_bank) |=> (bank_ovr_vld && bank_ovr == $past(want_code)));

    assert_keep_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (retire_vld && retire_cls == 4'd9) |=> (ccr_wb_inhibit && $stable(bank_ovr)));

    assert_run_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (retire_vld && is_plain_sup) |=>
            ($stable(bank_ovr) && $stable(ccr_wb_inhibit) && $stable(shared_sel)));

    assert_ord_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (retire_vld && is_ord) |=> (!bank_ovr_vld && !ccr_wb_inhibit && !shared_sel));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!irq_accept && !bank_ovr_vld && !ccr_wb_inhibit && !shared_sel));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !retire_vld |=> ($stable(bank_ovr) && $stable(ccr_wb_inhibit)
                         && $stable(shared_sel) && !irq_accept));

endmodule

bind pfx_irq_gate pfx_irq_gate_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .retire_vld     (retire_vld),
    .retire_cls     (retire_cls),
    .irq_req        (irq_req),
    .bank_ovr       (bank_ovr),
    .bank_ovr_vld   (bank_ovr_vld),
    .ccr_wb_inhibit (ccr_wb_inhibit),
    .shared_sel     (shared_sel),
    .irq_accept     (irq_accept)
);

// File: tb/test_pfx_irq_gate.sv
`timescale 1ns/1ps
module test_pfx_irq_gate;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       retire_vld = 1'b0;
    logic [3:0] retire_cls = 4'd0;
    logic       irq_req = 1'b0;
    logic [2:0] bank_ovr;
    logic       bank_ovr_vld;
    logic       ccr_wb_inhibit;
    logic       shared_sel;
    logic       irq_accept;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pfx_irq_gate i_pfx_irq_gate (
        .clk            (clk),
        .rst            (rst),
        .retire_vld     (retire_vld),
        .retire_cls     (retire_cls),
        .irq_req        (irq_req),
        .bank_ovr       (bank_ovr),
        .bank_ovr_vld   (bank_ovr_vld),
        .ccr_wb_inhibit (ccr_wb_inhibit),
        .shared_sel     (shared_sel),
        .irq_accept     (irq_accept)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic chk_state(input string req, input int bank, input int kc,
                             input int sh, input int acc);
        chk(req, "bank_ovr", int'(bank_ovr), bank);
        chk(req, "bank_ovr_vld", int'(bank_ovr_vld), (bank != 0) ? 1 : 0);
        chk(req, "ccr_wb_inhibit", int'(ccr_wb_inhibit), kc);
        chk(req, "shared_sel", int'(shared_sel), sh);
        chk(req, "irq_accept", int'(irq_accept), acc);
    endtask

    // one retire; returns at the negedge after the edge that samples it
    task automatic retire(input logic [3:0] cls, input logic req);
        @(negedge clk);
        retire_vld = 1'b1;
        retire_cls = cls;
        irq_req    = req;
        @(negedge clk);
        retire_vld = 1'b0;
        retire_cls = 4'd0;
        irq_req    = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk_state("R9", 0, 0, 0, 0);
    endtask

    task automatic t_plain_accept();
        retire(4'd0, 1'b1);
        chk_state("R2", 0, 0, 0, 1);
        @(negedge clk);
        chk("R2", "pulse width", int'(irq_accept), 0);
        retire(4'd0, 1'b0);
        chk("R2", "no request", int'(irq_accept), 0);
    endtask

    task automatic t_prefix_through_run();
        retire(4'd6, 1'b0);
        chk_state("R4", 2, 0, 0, 0);
        retire(4'd1, 1'b1);
        chk_state("R7", 2, 0, 0, 0);
        retire(4'd3, 1'b1);
        retire(4'd4, 1'b0);
        chk_state("R7", 2, 0, 0, 0);
        @(negedge clk);
        chk_state("R8", 2, 0, 0, 0);
        retire(4'd0, 1'b1);
        chk_state("R8", 0, 0, 0, 1);
    endtask

    task automatic t_conflict();
        retire(4'd5, 1'b0);
        chk_state("R4", 1, 0, 0, 0);
        retire(4'd8, 1'b0);
        retire(4'd7, 1'b0);
        chk_state("R5", 3, 0, 0, 0);
        retire(4'd2, 1'b0);
        retire(4'd8, 1'b0);
        chk_state("R5", 4, 0, 0, 0);
        retire(4'd0, 1'b0);
        chk_state("R8", 0, 0, 0, 0);
    endtask

    task automatic t_req_mid_run();
        retire(4'd1, 1'b0);
        retire(4'd9, 1'b1);
        chk_state("R3", 0, 1, 0, 0);
        retire(4'd2, 1'b1);
        chk_state("R3", 0, 1, 0, 0);
        retire(4'd10, 1'b1);
        chk_state("R3", 0, 1, 1, 0);
        retire(4'd0, 1'b1);
        chk_state("R3", 0, 0, 0, 1);
    endtask

    task automatic t_side_flags();
        retire(4'd9, 1'b0);
        retire(4'd6, 1'b0);
        chk_state("R6", 2, 1, 0, 0);
        retire(4'd10, 1'b0);
        chk_state("R6", 2, 1, 1, 0);
        retire(4'd5, 1'b0);
        chk_state("R6", 1, 1, 1, 0);
        retire(4'd0, 1'b0);
        chk_state("R8", 0, 0, 0, 0);
    endtask

    task automatic t_no_strobe();
        retire(4'd7, 1'b0);
        @(negedge clk);
        retire_vld = 1'b0;
        retire_cls = 4'd0;
        irq_req    = 1'b1;
        @(negedge clk);
        retire_cls = 4'd5;
        @(negedge clk);
        irq_req = 1'b0;
        chk_state("R10", 3, 0, 0, 0);
        retire(4'd0, 1'b0);
    endtask

    task automatic t_reserved();
        retire(4'd6, 1'b0);
        retire(4'd13, 1'b1);
        chk_state("R1", 0, 0, 0, 1);
        retire(4'd15, 1'b1);
        chk_state("R1", 0, 0, 0, 1);
        retire(4'd4, 1'b1);
        chk_state("R1", 0, 0, 0, 0);
        retire(4'd0, 1'b0);
    endtask

    task automatic t_reset_mid();
        retire(4'd8, 1'b0);
        retire(4'd9, 1'b0);
        @(negedge clk);
        rst        = 1'b1;
        retire_vld = 1'b1;
        retire_cls = 4'd0;
        irq_req    = 1'b1;
        @(negedge clk);
        rst        = 1'b0;
        retire_vld = 1'b0;
        irq_req    = 1'b0;
        chk_state("R9", 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_plain_accept();
        t_prefix_through_run();
        t_conflict();
        t_req_mid_run();
        t_side_flags();
        t_no_strobe();
        t_reserved();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule